// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. A convert command arms a conversion. The block then drives a trial word to an external DAC and reads back one comparator bit for each conversion clock. It settles one result bit per clock, starting at the most significant bit. When the last bit is settled, it loads the final word, in complementary coding, into a parallel result register.

While the conversion runs, each settled bit is also sent at once on a serial NRZ line, most significant bit first. A one-cycle conversion-clock pulse marks each serial update. The conversion clock comes either from an internal divider of the system clock or from an external enable strobe, and an inhibit input can pause it. A short-cycle input ends the conversion after ten bits, which gives a faster result with less resolution.

A busy flag is high for the whole conversion. A new convert command is accepted only while the sequencer is idle.

Top module: `sar_seq_ctrl`

## Requirements
- R1: With `short_sel` low, a conversion settles exactly NB bits, one for each conversion clock, from bit NB-1 down to bit 0. At the end, `trial_word` equals the largest code that the comparator did not report as above the input.
- R2: On the edge that accepts a command, `busy` rises, `trial_word` becomes only the MSB set, `result` becomes all zeros, and `ser_out` becomes 0.
- R3: `busy` stays high from the accepting edge up to the edge that settles the last bit, and falls on that edge. `result` changes only on the accepting edge and on that final edge.
- R4: The bit under trial is 1 when it is tried. On the next conversion clock it stays 1 if `cmp_high` is 0 and is cleared if `cmp_high` is 1, and the next lower bit is then set to 1 for its own trial.
- R5: With `short_sel` high, the conversion ends after SHORT_BITS settled bits. The lowest NB-SHORT_BITS bits of both `trial_word` and `result` are then 0.
- R6: `result` is coded by `code_sel`. The values 2'b00 (straight binary) and 2'b01 (offset binary) both give the bitwise complement of the raw word. The value 2'b10 (two's complement) gives the raw MSB followed by the complement of the remaining bits. The value 2'b11 behaves like 2'b01.
- R7: `ser_out` is updated on every settling edge with the settled bit, coded as in R6. It therefore carries the MSB first, and that MSB is uncomplemented under 2'b10. From the accepting edge until the first settling edge, `ser_out` holds 0.
- R8: The internal conversion clock fires once every CLK_DIV system cycles, counted from the release edge. With `use_ext_tick` high, it fires on each `ext_tick` cycle instead. While `clk_hold` is high, no conversion clock fires and the divider does not advance, so each held cycle adds one cycle to the conversion.
- R9: `conv_clk_out` is high for exactly one system cycle after each settling edge, and at no other time.
- R10: A command is accepted on a rising edge of `conv_req` while idle. The release edge is the first edge that samples the command low, or the CMD_MAX_CYC-th edge after acceptance if the command is still high. A command seen high on H edges gives a `busy` time of min(H, CMD_MAX_CYC) + bits × CLK_DIV cycles.
- R11: A rising edge of `conv_req` while `busy` is high is ignored: the running conversion keeps its length and its result, and no second conversion follows.
- R12: After reset, `busy`, `trial_word`, `result`, `ser_out` and `conv_clk_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Convert command, level input |
| cmp_high | input | 1 | Comparator result: 1 when the DAC output is above the input |
| short_sel | input | 1 | Stop after SHORT_BITS bits |
| clk_hold | input | 1 | Inhibit the conversion clock |
| use_ext_tick | input | 1 | Take the conversion clock from `ext_tick` |
| ext_tick | input | 1 | External conversion-clock enable strobe |
| code_sel | input | 2 | Output coding select (R6) |
| trial_word | output | NB | Trial word to the DAC |
| busy | output | 1 | Conversion in progress |
| conv_clk_out | output | 1 | One pulse for each settled bit |
| result | output | NB | Coded parallel result |
| ser_out | output | 1 | Serial NRZ data, MSB first |

## Verification
The assertions watch, on every cycle, the properties that depend only on local timing:
- the cleared state on acceptance;
- `result` frozen outside the two load edges;
- no conversion-clock pulse after an inhibited cycle or outside a conversion;
- a nonzero trial word while busy;
- zeroed low bits after a short cycle.

Only the bench scenarios can show the properties that need an analog model or a count over a whole conversion. These are the settled value against a behavioural comparator, each coding, the serial bit order, the exact busy length for short, long and inhibited commands, the external-strobe mode, and whether a second command is ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    CODE_CSB = 2'b00,
    CODE_COB = 2'b01,
    CODE_CTC = 2'b10,
    CODE_ALT = 2'b11
  } code_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_WAIT = 2'b01,
    PH_RUN  = 2'b10
  } phase_e;

endpackage

// File: rtl/sar_cmd_qual.sv
module sar_cmd_qual #(
  parameter int CMD_MAX_CYC = 4000,
  localparam int HW = $clog2(CMD_MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic busy,
  output logic start,
  output logic release_go
);

  logic          req_d;
  logic          waiting;
  logic [HW-1:0] hcnt;

  // accept only a fresh rising edge while idle
  assign start      = cmd & ~req_d & ~busy;
  // free the conversion when the command drops or the hold limit is reached
  assign release_go = waiting & (~cmd | (hcnt == HW'(CMD_MAX_CYC - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d   <= 1'b0;
      waiting <= 1'b0;
      hcnt    <= '0;
    end else begin
      req_d <= cmd;
      if (start) begin
        waiting <= 1'b1;
        hcnt    <= '0;
      end else if (release_go) begin
        waiting <= 1'b0;
      end else if (waiting) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int CLK_DIV = 360,
  localparam int CW = $clog2(CLK_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic use_ext,
  input  logic ext_tick,
  input  logic hold,
  output logic tick
);

  logic [CW-1:0] cnt;
  logic          div_hit;

  assign div_hit = (cnt == CW'(CLK_DIV - 1));
  assign tick    = run & ~hold & (use_ext ? ext_tick : div_hit);

  // divider restarts from zero at each release and freezes while held
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!hold) begin
      cnt <= div_hit ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_seq_pkg::*;
#(
  parameter int NB         = 12,
  parameter int SHORT_BITS = 10,
  localparam int IDXW      = $clog2(NB),
  localparam int DROP      = NB - SHORT_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          release_go,
  input  logic          tick,
  input  logic          cmp_high,
  input  logic          short_sel,
  input  logic [1:0]    code_sel,
  output logic          busy,
  output logic          running,
  output logic [NB-1:0] trial,
  output logic [NB-1:0] result,
  output logic          ser_bit,
  output logic          clk_pulse
);

  localparam logic [NB-1:0] TOP_BIT    = NB'(1) << (NB - 1);
  localparam logic [NB-1:0] KEEP_SHORT = {NB{1'b1}} << DROP;

  phase_e          phase;
  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] pos;
  logic            dec;
  logic            last;
  logic            ctc;
  logic [NB-1:0]   trial_nx;
  logic [NB-1:0]   coded;
  logic            ser_nx;

  assign running = (phase == PH_RUN);
  assign pos     = IDXW'(NB - 1) - idx;
  assign dec     = ~cmp_high;
  assign last    = (idx == IDXW'(NB - 1)) || (short_sel && (idx == IDXW'(SHORT_BITS - 1)));
  assign ctc     = (code_e'(code_sel) == CODE_CTC);

  always_comb begin
    trial_nx = trial;
    for (int b = 0; b < NB; b++) begin
      if (b == int'(pos)) trial_nx[b] = dec;
      if (!last && (b + 1 == int'(pos))) trial_nx[b] = 1'b1;
    end
  end

  assign coded  = ctc ? {trial_nx[NB-1], ~trial_nx[NB-2:0]} : ~trial_nx;
  assign ser_nx = (ctc && idx == '0) ? dec : ~dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      busy      <= 1'b0;
      idx       <= '0;
      trial     <= '0;
      result    <= '0;
      ser_bit   <= 1'b0;
      clk_pulse <= 1'b0;
    end else begin
      clk_pulse <= tick;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_WAIT;
            busy    <= 1'b1;
            idx     <= '0;
            trial   <= TOP_BIT;
            result  <= '0;
            ser_bit <= 1'b0;
          end
        end
        PH_WAIT: begin
          if (release_go) phase <= PH_RUN;
        end
        PH_RUN: begin
          if (tick) begin
            trial   <= trial_nx;
            ser_bit <= ser_nx;
            idx     <= idx + 1'b1;
            if (last) begin
              phase  <= PH_IDLE;
              busy   <= 1'b0;
              result <= coded & (short_sel ? KEEP_SHORT : {NB{1'b1}});
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int NB          = 12,
  parameter int SHORT_BITS  = 10,
  parameter int CLK_DIV     = 360,
  parameter int CMD_MAX_CYC = 4000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_req,
  input  logic          cmp_high,
  input  logic          short_sel,
  input  logic          clk_hold,
  input  logic          use_ext_tick,
  input  logic          ext_tick,
  input  logic [1:0]    code_sel,
  output logic [NB-1:0] trial_word,
  output logic          busy,
  output logic          conv_clk_out,
  output logic [NB-1:0] result,
  output logic          ser_out
);

  logic start;
  logic release_go;
  logic running;
  logic tick;

  sar_cmd_qual #(.CMD_MAX_CYC(CMD_MAX_CYC)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .cmd        (conv_req),
    .busy       (busy),
    .start      (start),
    .release_go (release_go)
  );

  sar_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (running),
    .use_ext  (use_ext_tick),
    .ext_tick (ext_tick),
    .hold     (clk_hold),
    .tick     (tick)
  );

  sar_bit_engine #(.NB(NB), .SHORT_BITS(SHORT_BITS)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .release_go (release_go),
    .tick       (tick),
    .cmp_high   (cmp_high),
    .short_sel  (short_sel),
    .code_sel   (code_sel),
    .busy       (busy),
    .running    (running),
    .trial      (trial_word),
    .result     (result),
    .ser_bit    (ser_out),
    .clk_pulse  (conv_clk_out)
  );

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int NB         = 12,
  parameter int SHORT_BITS = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_hold,
  input logic          short_sel,
  input logic          busy,
  input logic          conv_clk_out,
  input logic [NB-1:0] trial_word,
  input logic [NB-1:0] result
);

  localparam logic [NB-1:0] TOP_BIT = NB'(1) << (NB - 1);
  localparam int DROP = NB - SHORT_BITS;

  // R2: acceptance clears the result and tries the MSB alone
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (result == '0) && (trial_word == TOP_BIT));

  // R3: result moves only when busy changes
  a_r3_result_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy == $past(busy)) |-> $stable(result));

  // R4: a trial bit is always pending while busy
  a_r4_trial_live: assert property (@(posedge clk) disable iff (rst)
    busy |-> (trial_word != '0));

  // R5: a short cycle leaves the dropped bits at zero
  a_r5_short_tail: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(short_sel)) |->
      (trial_word[DROP-1:0] == '0) && (result[DROP-1:0] == '0));

  // R8: an inhibited cycle yields no conversion clock
  a_r8_inhibit: assert property (@(posedge clk) disable iff (rst)
    clk_hold |=> !conv_clk_out);

  // R9: clock output only inside a conversion
  a_r9_clk_gated: assert property (@(posedge clk) disable iff (rst)
    conv_clk_out |-> (busy || $past(busy)));

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.NB(NB), .SHORT_BITS(SHORT_BITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clk_hold     (clk_hold),
  .short_sel    (short_sel),
  .busy         (busy),
  .conv_clk_out (conv_clk_out),
  .trial_word   (trial_word),
  .result       (result)
);

// File: tb/sar_seq_ctrl_test.sv
`timescale 1ns/1ps
module sar_seq_ctrl_test;

  localparam int NB   = 12;
  localparam int SB   = 10;
  localparam int DIV  = 4;
  localparam int MAXC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_req = 1'b0;
  logic short_sel = 1'b0;
  logic clk_hold = 1'b0;
  logic use_ext_tick = 1'b0;
  logic ext_tick = 1'b0;
  logic [1:0] code_sel = 2'b00;
  logic [NB-1:0] vin = '0;
  logic cmp_high;
  logic [NB-1:0] trial_word;
  logic busy;
  logic conv_clk_out;
  logic [NB-1:0] result;
  logic ser_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  // behavioural comparator: DAC above the input
  assign cmp_high = (trial_word > vin);

  sar_seq_ctrl #(.NB(NB), .SHORT_BITS(SB), .CLK_DIV(DIV), .CMD_MAX_CYC(MAXC)) uut (
    .clk(clk), .rst(rst), .conv_req(conv_req), .cmp_high(cmp_high),
    .short_sel(short_sel), .clk_hold(clk_hold), .use_ext_tick(use_ext_tick),
    .ext_tick(ext_tick), .code_sel(code_sel), .trial_word(trial_word),
    .busy(busy), .conv_clk_out(conv_clk_out), .result(result), .ser_out(ser_out)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] enc(input logic [NB-1:0] raw, input logic [1:0] cs);
    enc = (cs == 2'b10) ? {raw[NB-1], ~raw[NB-2:0]} : ~raw;
  endfunction

  // one conversion; exp_busy < 0 skips the length check
  task automatic run_conv(input logic [NB-1:0] v, input logic [1:0] cs, input logic sh,
                          input int hlen, input int inh_at, input int inh_len,
                          input logic ext, input logic retrig, input int exp_busy, input string tag);
    int bc = 0;
    int pc = 0;
    int cyc = 0;
    logic seen = 1'b0;
    logic mid_bad = 1'b0;
    logic [NB-1:0] sb = '0;
    logic [NB-1:0] raw;
    int nbits;
    nbits = sh ? SB : NB;
    raw = sh ? (v & ({NB{1'b1}} << (NB - SB))) : v;
    @(negedge clk);
    vin = v; code_sel = cs; short_sel = sh; use_ext_tick = ext;
    conv_req = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cyc++;
      if (cyc == hlen) conv_req = 1'b0;
      if (retrig && cyc == 30) conv_req = 1'b1;
      if (retrig && cyc == 31) conv_req = 1'b0;
      if (inh_len > 0 && cyc == inh_at) clk_hold = 1'b1;
      if (inh_len > 0 && cyc == inh_at + inh_len) clk_hold = 1'b0;
      ext_tick = ext && (cyc % 3 == 0);
      if (cyc == 1) begin
        chk("R2", {tag, " busy on accept"}, busy, 1'b1);
        chk("R2", {tag, " trial on accept"}, trial_word, 12'h800);
        chk("R2", {tag, " result cleared"}, result, 0);
        chk("R7", {tag, " serial idle before first bit"}, ser_out, 1'b0);
      end
      if (busy) begin
        bc++;
        seen = 1'b1;
        if (result !== '0) mid_bad = 1'b1;
      end
      if (conv_clk_out) begin
        pc++;
        sb = {sb[NB-2:0], ser_out};
      end
      if (seen && !busy && !conv_clk_out) break;
    end
    conv_req = 1'b0; clk_hold = 1'b0; ext_tick = 1'b0;
    chk("R3", {tag, " result held while busy"}, mid_bad, 1'b0);
    chk(sh ? "R5" : "R1", {tag, " final trial word"}, trial_word, raw);
    chk("R6", {tag, " coded result"}, result,
        enc(raw, cs) & (sh ? ({NB{1'b1}} << (NB - SB)) : {NB{1'b1}}));
    chk("R7", {tag, " serial bits"}, sb, enc(raw, cs) >> (NB - nbits));
    chk("R9", {tag, " clock pulses"}, pc, nbits);
    if (exp_busy >= 0) chk("R10", {tag, " busy length"}, bc, exp_busy);
  endtask

  task automatic t_reset();
    chk("R12", "busy after reset", busy, 1'b0);
    chk("R12", "trial after reset", trial_word, 0);
    chk("R12", "result after reset", result, 0);
    chk("R12", "serial after reset", ser_out, 1'b0);
    chk("R12", "clock out after reset", conv_clk_out, 1'b0);
  endtask

  task automatic t_codings();
    run_conv(12'hA5C, 2'b00, 1'b0, 1, 0, 0, 1'b0, 1'b0, 1 + NB*DIV, "R1 straight");
    run_conv(12'h000, 2'b01, 1'b0, 1, 0, 0, 1'b0, 1'b0, 1 + NB*DIV, "R4 zero offset");
    run_conv(12'hFFF, 2'b10, 1'b0, 1, 0, 0, 1'b0, 1'b0, 1 + NB*DIV, "R6 full twos");
    run_conv(12'h800, 2'b10, 1'b0, 1, 0, 0, 1'b0, 1'b0, 1 + NB*DIV, "R6 mid twos");
    run_conv(12'h7FF, 2'b11, 1'b0, 1, 0, 0, 1'b0, 1'b0, 1 + NB*DIV, "R6 alt code");
  endtask

  task automatic t_short();
    run_conv(12'h3FF, 2'b00, 1'b1, 1, 0, 0, 1'b0, 1'b0, 1 + SB*DIV, "R5 short straight");
    run_conv(12'h801, 2'b10, 1'b1, 1, 0, 0, 1'b0, 1'b0, 1 + SB*DIV, "R5 short twos");
  endtask

  task automatic t_long_cmd();
    run_conv(12'h456, 2'b00, 1'b0, 6, 0, 0, 1'b0, 1'b0, 6 + NB*DIV, "R10 held six");
    run_conv(12'hBCD, 2'b01, 1'b0, 40, 0, 0, 1'b0, 1'b0, MAXC + NB*DIV, "R10 held past limit");
  endtask

  task automatic t_inhibit();
    run_conv(12'h9A3, 2'b00, 1'b0, 1, 10, 10, 1'b0, 1'b0, 1 + NB*DIV + 10, "R8 inhibit");
  endtask

  task automatic t_ext();
    run_conv(12'h123, 2'b10, 1'b0, 1, 0, 0, 1'b1, 1'b0, -1, "R8 external strobe");
  endtask

  task automatic t_retrig();
    logic again = 1'b0;
    run_conv(12'h6E1, 2'b00, 1'b0, 1, 0, 0, 1'b0, 1'b1, 1 + NB*DIV, "R11 retrigger");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (busy) again = 1'b1;
    end
    chk("R11", "no second conversion", again, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_codings();
    t_short();
    t_long_cmd();
    t_inhibit();
    t_ext();
    t_retrig();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule